// File: doc/BRIEF.md
# Load-Use Stall Detection Unit

This block sits in the decode stage of a five-stage in-order pipeline. Every cycle it looks at the instruction in the IF/ID latch and at the instruction one stage ahead in ID/EX. It decides whether the decode-stage instruction needs a value that a load in ID/EX is still fetching from memory. A loaded word exists only at the end of the memory stage, so an instruction right behind the load cannot get it in time, even with forwarding. In that one case the unit holds the PC and the IF/ID latch for one cycle and tells the ID/EX latch to take a bubble. The bubble is an instruction whose register-write, memory-write and branch control bits are cleared.

The unit keeps its own small copy of what enters ID/EX: a load flag and the load's destination (rt) field. It captures this copy from IF/ID on every clock edge. When a stall is raised, it captures a bubble into the copy instead. This is why a stall can last only one cycle. On the next cycle the consumer sits in EX beside the load's write-back, and forwarding supplies the value. All other read-after-write cases are left to the forwarding logic and do not stall.

Opcodes are 6 bits: register-register ALU `6'h00`, load `6'h20`, store `6'h28`, two-register branches `6'h04` and `6'h05`, immediate ALU `6'h08`..`6'h0E`, upper-immediate `6'h0F`, jump `6'h02`.

Top module: `lus_load_use_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, outputs are `pc_we`=1, `ifid_we`=1, `idex_bubble`=0, whatever is in IF/ID.
- R2: If the previous cycle's IF/ID instruction was a load (`6'h20`) with nonzero rt, and the current IF/ID instruction reads rs equal to that rt, the unit stalls.
- R3: The rt source field is compared only for opcodes that read rt: `6'h00`, `6'h28`, `6'h04`, `6'h05`. A match there stalls.
- R4: Immediate ALU ops (`6'h08`..`6'h0E`) and loads do not read rt, so an rt match alone does not stall them. A load whose rs matches does stall.
- R5: A load whose destination is register 0 never causes a stall.
- R6: A stall lasts exactly one cycle. On the next cycle the same held consumer does not stall again.
- R7: During a stall `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. Otherwise the outputs are 1, 1, 0.
- R8: A non-load producer (register-register ALU op or store) ahead of a consumer never causes a stall.
- R9: Jump (`6'h02`) and upper-immediate (`6'h0F`) read no register and never stall.
- R10: A load two instructions ahead of its consumer (one unrelated instruction between them) causes no stall.
- R11: In back-to-back loads where the second uses the first's result, the second stalls once. After that, a consumer of the second load stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ifid_op | input | 6 | Opcode of the instruction in IF/ID |
| ifid_rs | input | REG_AW | rs field of the instruction in IF/ID |
| ifid_rt | input | REG_AW | rt field of the instruction in IF/ID |
| pc_we | output | 1 | PC write enable, low while stalled |
| ifid_we | output | 1 | IF/ID latch write enable, low while stalled |
| idex_bubble | output | 1 | Load a bubble into ID/EX this cycle |

## Verification
The hardest situation to reach is the stall that depends on another stall: a load that is itself the consumer of the previous load, and that must then stall its own consumer. To get there, the stimulus plays the frozen pipeline's part. It keeps the stalled instruction in IF/ID for a second cycle, as the real latch would, then moves on to the next consumer. This shows that the bubble replaced only the first load's record and kept the second. The register-0 destination and the opcodes that ignore rt are covered by pairs in which the field matches but no stall may follow.

// File: rtl/lus_pkg.sv
package lus_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RREG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNE  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_IMLO  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_IMHI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_UPIM  = 6'h0F;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h20;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h28;

  // How an instruction uses its register fields
  typedef struct packed {
    logic reads_rs;
    logic reads_rt;
    logic is_load;
  } src_use_t;

endpackage

// File: rtl/lus_src_decode.sv
module lus_src_decode
  import lus_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output src_use_t         use_o
);

  always_comb begin
    use_o = '0;
    unique case (op)
      OPC_RREG, OPC_STORE, OPC_BREQ, OPC_BRNE: begin
        use_o.reads_rs = 1'b1;
        use_o.reads_rt = 1'b1;
      end
      OPC_LOAD: begin
        use_o.reads_rs = 1'b1;
        use_o.is_load  = 1'b1;
      end
      OPC_JUMP, OPC_UPIM: begin
        use_o = '0;
      end
      default: begin
        // immediate ALU group and any other opcode: base register only
        use_o.reads_rs = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (op >= OPC_IMLO && op <= OPC_IMHI) begin
      AST_IMM_NO_RT: assert (!use_o.reads_rt); // R4
    end
  end

endmodule

// File: rtl/lus_idex_track.sv
module lus_idex_track #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bubble_i,
  input  logic              ld_i,
  input  logic [REG_AW-1:0] dst_i,
  output logic              ld_q,
  output logic [REG_AW-1:0] dst_q
);

  logic              ld_d;
  logic [REG_AW-1:0] dst_d;

  // next state: a bubble replaces the record of the decode-stage instruction
  always_comb begin
    if (bubble_i) begin
      ld_d  = 1'b0;
      dst_d = '0;
    end else begin
      ld_d  = ld_i;
      dst_d = dst_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      dst_q <= '0;
    end else begin
      ld_q  <= ld_d;
      dst_q <= dst_d;
    end
  end

  AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_i |=> !ld_q); // R6

endmodule

// File: rtl/lus_hazard_cmp.sv
module lus_hazard_cmp #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trk_ld,
  input  logic [REG_AW-1:0] trk_dst,
  input  logic [REG_AW-1:0] src_reg [NSRC],
  input  logic [NSRC-1:0]   src_en,
  output logic              hazard
);

  logic [NSRC-1:0] hit;
  logic            dst_live;

  assign dst_live = trk_ld && (trk_dst != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = dst_live && src_en[s] && (src_reg[s] == trk_dst);
  end

  assign hazard = |hit;

  AST_NO_R0_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (trk_dst != '0)); // R5
  AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> trk_ld); // R8

endmodule

// File: rtl/lus_load_use_unit.sv
module lus_load_use_unit
  import lus_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  ifid_op,
  input  logic [REG_AW-1:0] ifid_rs,
  input  logic [REG_AW-1:0] ifid_rt,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble
);

  localparam int NSRC = 2;

  src_use_t          dec_use;
  logic              trk_ld;
  logic [REG_AW-1:0] trk_dst;
  logic [REG_AW-1:0] src_reg [NSRC];
  logic [NSRC-1:0]   src_en;
  logic              stall;

  lus_src_decode u_dec (
    .op    (ifid_op),
    .use_o (dec_use)
  );

  lus_idex_track #(.REG_AW(REG_AW)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bubble_i (stall),
    .ld_i     (dec_use.is_load),
    .dst_i    (ifid_rt),
    .ld_q     (trk_ld),
    .dst_q    (trk_dst)
  );

  assign src_reg[0] = ifid_rs;
  assign src_reg[1] = ifid_rt;
  assign src_en     = {dec_use.reads_rt, dec_use.reads_rs};

  lus_hazard_cmp #(.REG_AW(REG_AW), .NSRC(NSRC)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .trk_ld  (trk_ld),
    .trk_dst (trk_dst),
    .src_reg (src_reg),
    .src_en  (src_en),
    .hazard  (stall)
  );

  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble); // R6
  AST_STALL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> ($past(ifid_op) == OPC_LOAD)); // R2
  AST_FREEZE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we)); // R7

endmodule

// File: tb/lus_load_use_unit_bench.sv
`timescale 1ns/1ps
module lus_load_use_unit_bench;

  localparam int RW = 5;
  localparam logic [5:0] RREG = 6'h00, JMP = 6'h02, BEQ = 6'h04, ADDI = 6'h08,
                         UPIM = 6'h0F, LD = 6'h20, ST = 6'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] op = RREG;
  logic [RW-1:0] rs = '0, rt = '0;
  logic pc_we, ifid_we, idex_bubble;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lus_load_use_unit #(.REG_AW(RW)) u_lus_load_use_unit (
    .clk(clk), .rst_n(rst_n), .ifid_op(op), .ifid_rs(rs), .ifid_rt(rt),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble));

  task automatic chk(input logic exp_stall, input string tag);
    logic [2:0] got, exp;
    got = {pc_we, ifid_we, idex_bubble};
    exp = exp_stall ? 3'b001 : 3'b110;
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s pc_we/ifid_we/bubble actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // present one IF/ID instruction for a cycle and check the outputs
  task automatic step(input logic [5:0] o, input logic [RW-1:0] s, input logic [RW-1:0] t,
                      input logic exp_stall, input string tag);
    @(negedge clk);
    op = o; rs = s; rt = t;
    #1 chk(exp_stall, tag);
  endtask

  task automatic nop();
    step(RREG, '0, '0, 1'b0, "flush");
  endtask

  task automatic t_reset();
    op = LD; rs = 5'd1; rt = 5'd5;
    @(negedge clk); #1 chk(1'b0, "R1 in reset");
    op = RREG; rs = 5'd5; rt = 5'd5;
    @(negedge clk); #1 chk(1'b0, "R1 in reset, consumer");
    rst_n = 1'b1;
    #1 chk(1'b0, "R1 first cycle after reset");
  endtask

  task automatic t_rs_dep();
    nop();
    step(LD, 5'd2, 5'd5, 1'b0, "R2 load");
    step(RREG, 5'd5, 5'd3, 1'b1, "R2 rs match stall, R7 outputs");
    step(RREG, 5'd5, 5'd3, 1'b0, "R6 held consumer released");
  endtask

  task automatic t_rt_dep();
    nop();
    step(LD, 5'd1, 5'd7, 1'b0, "R3 load");
    step(ST, 5'd3, 5'd7, 1'b1, "R3 store rt match");
    step(ST, 5'd3, 5'd7, 1'b0, "R6 store released");
    step(LD, 5'd1, 5'd8, 1'b0, "R3 load");
    step(BEQ, 5'd2, 5'd8, 1'b1, "R3 branch rt match");
    step(BEQ, 5'd2, 5'd8, 1'b0, "R6 branch released");
    step(LD, 5'd1, 5'd9, 1'b0, "R3 load");
    step(RREG, 5'd4, 5'd9, 1'b1, "R3 reg-reg rt match");
    step(RREG, 5'd4, 5'd9, 1'b0, "R6 reg-reg released");
  endtask

  task automatic t_no_rt();
    nop();
    step(LD, 5'd1, 5'd7, 1'b0, "R4 load");
    step(ADDI, 5'd3, 5'd7, 1'b0, "R4 immediate op rt ignored");
    step(LD, 5'd1, 5'd6, 1'b0, "R4 load");
    step(LD, 5'd4, 5'd6, 1'b0, "R4 load rt ignored");
    step(ADDI, 5'd6, 5'd1, 1'b1, "R4 immediate op rs match");
    step(ADDI, 5'd6, 5'd1, 1'b0, "R6 immediate released");
  endtask

  task automatic t_r0();
    nop();
    step(LD, 5'd3, 5'd0, 1'b0, "R5 load to r0");
    step(RREG, 5'd0, 5'd0, 1'b0, "R5 consumer of r0");
  endtask

  task automatic t_nonload();
    nop();
    step(RREG, 5'd1, 5'd2, 1'b0, "R8 reg-reg producer");
    step(RREG, 5'd2, 5'd2, 1'b0, "R8 after reg-reg");
    step(ST, 5'd1, 5'd4, 1'b0, "R8 store producer");
    step(RREG, 5'd4, 5'd4, 1'b0, "R8 after store");
  endtask

  task automatic t_nosrc();
    nop();
    step(LD, 5'd1, 5'd6, 1'b0, "R9 load");
    step(JMP, 5'd6, 5'd6, 1'b0, "R9 jump");
    step(LD, 5'd1, 5'd6, 1'b0, "R9 load");
    step(UPIM, 5'd6, 5'd6, 1'b0, "R9 upper-immediate");
  endtask

  task automatic t_distance2();
    nop();
    step(LD, 5'd1, 5'd4, 1'b0, "R10 load");
    step(RREG, 5'd0, 5'd0, 1'b0, "R10 unrelated");
    step(RREG, 5'd4, 5'd4, 1'b0, "R10 consumer at distance two");
  endtask

  task automatic t_chain();
    nop();
    step(LD, 5'd1, 5'd3, 1'b0, "R11 first load");
    step(LD, 5'd3, 5'd9, 1'b1, "R11 second load stalls");
    step(LD, 5'd3, 5'd9, 1'b0, "R11 second load released");
    step(RREG, 5'd9, 5'd2, 1'b1, "R11 consumer of second load stalls");
    step(RREG, 5'd9, 5'd2, 1'b0, "R11 consumer released");
  endtask

  task automatic t_midreset();
    nop();
    step(LD, 5'd1, 5'd5, 1'b0, "R1 load before reset");
    @(negedge clk);
    rst_n = 1'b0; op = RREG; rs = 5'd5; rt = 5'd5;
    #1 chk(1'b0, "R1 reset drops pending load");
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(1'b0, "R1 after mid-run reset");
  endtask

  initial begin
    t_reset();
    t_rs_dep();
    t_rt_dep();
    t_no_rt();
    t_r0();
    t_nonload();
    t_nosrc();
    t_distance2();
    t_chain();
    t_midreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule